// File: doc/BRIEF.md
# Edge-Triggered DMA Block Transfer Sequencer

This block is the request front end and transfer engine of a single DMA channel. An external active-low request pin asks for work. The block turns each falling edge on that pin into exactly one block transfer. Software loads the source address, destination address, block length and number of blocks with a single configuration write strobe, and sets the channel enable in the same write.

From the clock edge after that write, the block samples the pin once per cycle. A low sample, taken while acceptance is open, is latched as a pending request. The block then raises a bus request and holds it until grant. The cycle in which grant is first seen activates the channel. Activation clears the pending request and moves the pin sampler from looking for a low level to looking for a high level.

The block then moves one block of data. Each unit is read from the source and then written to the destination. After the last unit comes one dead cycle, and then the bus is released for a fixed minimum time. Acceptance reopens once a high level has been seen on the pin after activation, so a pin held low never starts a second block. When the last programmed block finishes, the channel disables itself and pulses a done flag.

Top module: `dma_blk_seq`

## Requirements
- R1: The pin is first sampled on the rising edge after the configuration write that sets the enable. A low level present only during the write cycle is not taken. After the first low sample, `bus_req` is high from the following cycle.
- R2: A latched request holds `bus_req` high, with no memory access, for as long as `bus_gnt` stays low. The first read is issued in the cycle after the first cycle in which grant is seen.
- R3: Each accepted request moves exactly `cfg_size` units. A read at the source address is followed by a write at the destination address, and the write data equals the data returned by the preceding read. Both addresses advance by `ADDR_STEP` per access and carry on across blocks.
- R4: `mem_rd` and `mem_wr` are high only in cycles where `bus_gnt` is high, and never both at once. A grant gap stalls the block without skipping a unit.
- R5: After the last write of a block comes one dead cycle, in which `bus_req` is high and there is no access. `bus_req` is low in the next cycle and stays low for at least `MIN_GAP` cycles.
- R6: A pin held low continuously starts exactly one block.
- R7: A low level seen after activation and before the dead cycle ends is ignored. If a high level was seen by the end of the dead cycle, acceptance reopens at once. A pin that goes low during the block then starts the next block after `MIN_GAP`+1 bus-free cycles.
- R8: If no high level was seen by the end of the dead cycle, acceptance reopens on the first high sample after it. A later low sample then starts a block.
- R9: After `cfg_count` blocks, `done` is high for one cycle. That cycle directly follows the last dead cycle. `chan_en` is low from the same cycle, and the pin is then ignored until the next enabling write.
- R10: After reset, `bus_req`, `mem_rd`, `mem_wr`, `done` and `chan_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Channel enable value written with `cfg_wr` |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_size | input | SZW | Units per block (at least 1) |
| cfg_count | input | CNTW | Number of blocks (at least 1) |
| req_n | input | 1 | Active-low transfer request pin |
| bus_gnt | input | 1 | Bus grant |
| mem_rdata | input | DW | Read data returned in the read cycle |
| bus_req | output | 1 | Bus request |
| mem_rd | output | 1 | Read strobe (gated by grant) |
| mem_wr | output | 1 | Write strobe (gated by grant) |
| mem_addr | output | AW | Access address: source while reading, destination otherwise |
| mem_wdata | output | DW | Write data |
| done | output | 1 | One-cycle pulse after the last block |
| chan_en | output | 1 | Channel enable state |

## Verification
The main function is swept over block lengths of 1 to 4 and block counts of 1 to 3. Each combination runs under three grant patterns: grant always given, grant every other cycle, and grant missing every third cycle. This separates correct stalling from skipped or repeated units, and it shows that address progress carries across blocks.

Directed pin waveforms cover the edge detector. They include a low level present before enabling, a pin held low for many blocks' worth of time, a low pulse inside a block, and a low that begins inside a block after a high sample. These tell apart an edge detector, a level detector, and one that reopens too late or too early. The measured bus-free gap distinguishes immediate reopening from delayed reopening.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_WR,
    ST_DEAD,
    ST_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    SM_OPEN,    // accepting: look for a low level
    SM_ARMED,   // block running, no high seen yet
    SM_HISEEN,  // block running, high already seen
    SM_POST     // block over, still waiting for a high
  } samp_state_e;

  function automatic logic [31:0] addr_step(input logic [31:0] a, input logic [31:0] step);
    return a + step;
  endfunction

  function automatic logic is_final(input logic [31:0] left);
    return left == 32'd1;
  endfunction

endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler
  import dma_blk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_n,
  input  logic activate,
  input  logic dead_end,
  output logic held,
  output logic accept_open
);

  samp_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SM_OPEN;
      held <= 1'b0;
    end else if (!en) begin
      st_q <= SM_OPEN;
      held <= 1'b0;
    end else begin
      unique case (st_q)
        SM_OPEN: begin
          if (activate) begin
            held <= 1'b0;
            st_q <= SM_ARMED;
          end else if (!req_n) begin
            held <= 1'b1;
          end
        end
        SM_ARMED: begin
          if (dead_end) st_q <= req_n ? SM_OPEN : SM_POST;
          else if (req_n) st_q <= SM_HISEEN;
        end
        SM_HISEEN: begin
          if (dead_end) st_q <= SM_OPEN;
        end
        SM_POST: begin
          if (req_n) st_q <= SM_OPEN;
        end
        default: st_q <= SM_OPEN;
      endcase
    end
  end

  assign accept_open = en && (st_q == SM_OPEN);

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr
  import dma_blk_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SZW       = 4,
  parameter int CNTW      = 4,
  parameter int ADDR_STEP = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   src_in,
  input  logic [AW-1:0]   dst_in,
  input  logic [SZW-1:0]  size_in,
  input  logic [CNTW-1:0] count_in,
  input  logic            activate,
  input  logic            rd_fire,
  input  logic            wr_fire,
  input  logic            blk_end,
  input  logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   dst_addr,
  output logic [DW-1:0]   wr_data,
  output logic            beat_last,
  output logic            blk_last
);

  logic [SZW-1:0]  size_cfg_q;
  logic [SZW-1:0]  size_left_q;
  logic [CNTW-1:0] blk_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr    <= '0;
      dst_addr    <= '0;
      wr_data     <= '0;
      size_cfg_q  <= '0;
      size_left_q <= '0;
      blk_left_q  <= '0;
    end else if (load) begin
      src_addr    <= src_in;
      dst_addr    <= dst_in;
      size_cfg_q  <= size_in;
      size_left_q <= size_in;
      blk_left_q  <= count_in;
    end else begin
      if (activate) size_left_q <= size_cfg_q;
      if (rd_fire) begin
        src_addr <= AW'(addr_step(32'(src_addr), 32'(ADDR_STEP)));
        wr_data  <= rd_data;
      end
      if (wr_fire) begin
        dst_addr    <= AW'(addr_step(32'(dst_addr), 32'(ADDR_STEP)));
        size_left_q <= size_left_q - 1'b1;
      end
      if (blk_end) blk_left_q <= blk_left_q - 1'b1;
    end
  end

  assign beat_last = is_final(32'(size_left_q));
  assign blk_last  = is_final(32'(blk_left_q));

endmodule

// File: rtl/dma_block_fsm.sv
module dma_block_fsm
  import dma_blk_pkg::*;
#(
  parameter int MIN_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic held,
  input  logic bus_gnt,
  input  logic beat_last,
  input  logic blk_last,
  output logic bus_req,
  output logic rd_en,
  output logic wr_en,
  output logic rd_phase,
  output logic activate,
  output logic dead_end,
  output logic last_end,
  output logic done
);

  localparam int GW = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;

  seq_state_e    st_q;
  logic [GW-1:0] gap_q;

  assign bus_req  = (st_q == ST_ARB) || (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_DEAD);
  assign rd_phase = (st_q == ST_RD);
  assign rd_en    = rd_phase && bus_gnt;
  assign wr_en    = (st_q == ST_WR) && bus_gnt;
  assign activate = (st_q == ST_ARB) && bus_gnt;
  assign dead_end = (st_q == ST_DEAD);
  assign last_end = dead_end && blk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      gap_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_end;
      unique case (st_q)
        ST_IDLE: if (en && held) st_q <= ST_ARB;
        ST_ARB:  if (bus_gnt) st_q <= ST_RD;
        ST_RD:   if (bus_gnt) st_q <= ST_WR;
        ST_WR:   if (bus_gnt) st_q <= beat_last ? ST_DEAD : ST_RD;
        ST_DEAD: begin
          st_q  <= ST_GAP;
          gap_q <= GW'(MIN_GAP - 1);
        end
        ST_GAP: begin
          if (gap_q == '0) st_q <= ST_IDLE;
          else gap_q <= gap_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SZW       = 4,
  parameter int CNTW      = 4,
  parameter int ADDR_STEP = 1,
  parameter int MIN_GAP   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_en,
  input  logic [AW-1:0]   cfg_src,
  input  logic [AW-1:0]   cfg_dst,
  input  logic [SZW-1:0]  cfg_size,
  input  logic [CNTW-1:0] cfg_count,
  input  logic            req_n,
  input  logic            bus_gnt,
  input  logic [DW-1:0]   mem_rdata,
  output logic            bus_req,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            done,
  output logic            chan_en
);

  logic          en_q;
  logic          held;
  logic          accept_open;
  logic          activate;
  logic          dead_end;
  logic          last_end;
  logic          rd_phase;
  logic          beat_last;
  logic          blk_last;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (cfg_wr)   en_q <= cfg_en;
    else if (last_end) en_q <= 1'b0;
  end

  assign chan_en = en_q;

  dma_req_sampler u_samp (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en_q),
    .req_n       (req_n),
    .activate    (activate),
    .dead_end    (dead_end),
    .held        (held),
    .accept_open (accept_open)
  );

  dma_xfer_ctr #(
    .AW        (AW),
    .DW        (DW),
    .SZW       (SZW),
    .CNTW      (CNTW),
    .ADDR_STEP (ADDR_STEP)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_wr),
    .src_in    (cfg_src),
    .dst_in    (cfg_dst),
    .size_in   (cfg_size),
    .count_in  (cfg_count),
    .activate  (activate),
    .rd_fire   (mem_rd),
    .wr_fire   (mem_wr),
    .blk_end   (dead_end),
    .rd_data   (mem_rdata),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .wr_data   (mem_wdata),
    .beat_last (beat_last),
    .blk_last  (blk_last)
  );

  dma_block_fsm #(
    .MIN_GAP (MIN_GAP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .held      (held),
    .bus_gnt   (bus_gnt),
    .beat_last (beat_last),
    .blk_last  (blk_last),
    .bus_req   (bus_req),
    .rd_en     (mem_rd),
    .wr_en     (mem_wr),
    .rd_phase  (rd_phase),
    .activate  (activate),
    .dead_end  (dead_end),
    .last_end  (last_end),
    .done      (done)
  );

  assign mem_addr = rd_phase ? src_addr : dst_addr;

endmodule

// File: rtl/dma_blk_seq_chk.sv
module dma_blk_seq_chk #(
  parameter int MIN_GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic chan_en,
  input logic bus_req,
  input logic bus_gnt,
  input logic mem_rd,
  input logic mem_wr,
  input logic done,
  input logic activate,
  input logic dead_end,
  input logic held,
  input logic accept_open
);

  localparam int LW = $clog2(MIN_GAP + 1) + 1;

  logic [LW-1:0] low_cnt_q;
  logic          had_dead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q  <= '0;
      had_dead_q <= 1'b0;
    end else begin
      if (dead_end) had_dead_q <= 1'b1;
      if (bus_req) low_cnt_q <= '0;
      else if (low_cnt_q < LW'(MIN_GAP)) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  a_r4_rd_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> bus_gnt);
  a_r4_wr_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> bus_gnt);
  a_r4_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r2_activate_needs_held: assert property (@(posedge clk) disable iff (!rst_n)
    activate |-> (held && bus_req));
  a_r2_held_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    activate |=> !held);
  a_r7_closed_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !accept_open);
  a_r5_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dead_end |-> (bus_req && !mem_rd && !mem_wr));
  a_r5_drop_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
    dead_end |=> !bus_req);
  a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && had_dead_q) |-> (low_cnt_q >= LW'(MIN_GAP)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(cfg_wr)) |-> !chan_en);
  a_r9_no_held_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !held);

endmodule

bind dma_blk_seq dma_blk_seq_chk #(.MIN_GAP(MIN_GAP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .chan_en     (chan_en),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .done        (done),
  .activate    (activate),
  .dead_end    (dead_end),
  .held        (held),
  .accept_open (accept_open)
);

// File: tb/dma_blk_seq_tb.sv
module dma_blk_seq_tb;
  localparam int AW = 16, DW = 8, SZW = 4, CNTW = 4, STEP = 1, GAP = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_wr = 1'b0, cfg_en = 1'b0;
  logic [AW-1:0]   cfg_src = '0, cfg_dst = '0;
  logic [SZW-1:0]  cfg_size = '0;
  logic [CNTW-1:0] cfg_count = '0;
  logic            req_n = 1'b1;
  logic            bus_gnt = 1'b0;
  logic [DW-1:0]   mem_rdata;
  logic            bus_req, mem_rd, mem_wr, done, chan_en;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;

  dma_blk_seq #(.AW(AW), .DW(DW), .SZW(SZW), .CNTW(CNTW), .ADDR_STEP(STEP), .MIN_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_size(cfg_size), .cfg_count(cfg_count), .req_n(req_n),
    .bus_gnt(bus_gnt), .mem_rdata(mem_rdata), .bus_req(bus_req), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .chan_en(chan_en)
  );

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus clocking: every drive happens 2 ns after a rising edge
  int gmode = 0, cyc = 0;
  task automatic tick();
    @(posedge clk);
    #2;
    cyc++;
    case (gmode)
      0: bus_gnt = bus_req;
      1: bus_gnt = bus_req && cyc[0];
      2: bus_gnt = bus_req && (cyc % 3 != 2);
      default: bus_gnt = 1'b0;
    endcase
  endtask

  // monitor state
  logic [AW-1:0] exp_src, exp_dst, last_rd;
  int cur_size = 1, cur_count = 1, beats = 0, dead_pend = 0;
  int blk_started = 0, blk_ended = 0, done_cnt = 0, low_run = 0, last_gap = 0;
  bit prev_done = 0, had_block = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dead_pend == 2) begin
        check(!bus_req, "R5 bus released after dead cycle", bus_req, 0);
        check(done == (blk_ended == cur_count), "R9 done timing", done, blk_ended == cur_count);
        dead_pend = 0;
      end
      if (dead_pend == 1) begin
        check(bus_req && !mem_rd && !mem_wr, "R5 dead cycle", {bus_req, mem_rd, mem_wr}, 4);
        blk_ended++;
        dead_pend = 2;
      end
      if (mem_rd || mem_wr) check(bus_gnt, "R4 access only with grant", bus_gnt, 1);
      if (mem_rd) begin
        check(mem_addr == exp_src, "R3 read address", mem_addr, exp_src);
        last_rd = exp_src;
        exp_src = exp_src + STEP;
      end
      if (mem_wr) begin
        check(mem_addr == exp_dst, "R3 write address", mem_addr, exp_dst);
        check(mem_wdata == mem_fn(last_rd), "R3 write data", mem_wdata, mem_fn(last_rd));
        exp_dst = exp_dst + STEP;
        beats++;
        if (beats == cur_size) begin
          beats = 0;
          dead_pend = 1;
        end
      end
      if (done && prev_done) check(0, "R9 done longer than one cycle", 2, 1);
      if (done) done_cnt++;
      prev_done = done;
      if (bus_req) begin
        if (low_run > 0 || !had_block) begin
          blk_started++;
          if (had_block) begin
            last_gap = low_run;
            check(low_run >= GAP, "R5 minimum bus-free gap", low_run, GAP);
          end
        end
        had_block = 1;
        low_run = 0;
      end else begin
        low_run++;
      end
    end
  end

  task automatic configure(input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input int sz, input int ct, input int gm);
    gmode = gm;
    exp_src = s; exp_dst = d; cur_size = sz; cur_count = ct;
    beats = 0; blk_ended = 0; done_cnt = 0;
    tick();
    cfg_wr = 1'b1; cfg_en = 1'b1; cfg_src = s; cfg_dst = d;
    cfg_size = SZW'(sz); cfg_count = CNTW'(ct);
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse();
    tick(); req_n = 1'b0;
    tick(); req_n = 1'b1;
  endtask

  task automatic wait_end(input int n);
    for (int k = 0; k < 500 && blk_ended < n; k++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) tick();
    @(negedge clk);
    check({bus_req, mem_rd, mem_wr, done, chan_en} == 5'b0, "R10 reset outputs",
          {bus_req, mem_rd, mem_wr, done, chan_en}, 0);
    tick(); rst_n = 1'b1;
    repeat (2) tick();

    // R1 / R2: low already present during the enabling write, no grant yet
    req_n = 1'b0;
    configure(16'h0400, 16'h0800, 2, 1, 3);
    @(negedge clk); check(!bus_req, "R1 write cycle not sampled", bus_req, 0);
    tick(); @(negedge clk); check(!bus_req, "R1 first sample edge", bus_req, 0);
    tick(); @(negedge clk); check(bus_req, "R1 request raised", bus_req, 1);
    repeat (4) tick();
    @(negedge clk); check(bus_req && !mem_rd, "R2 request held without grant", {bus_req, mem_rd}, 2);
    gmode = 0; req_n = 1'b1;
    tick(); @(negedge clk); check(!mem_rd, "R2 no read in grant cycle", mem_rd, 0);
    tick(); @(negedge clk); check(mem_rd, "R2 read after first grant", mem_rd, 1);
    wait_end(1);
    repeat (4) tick();
    check(done_cnt == 1 && !chan_en, "R9 single block run", done_cnt, 1);

    // sweep: sizes x counts x grant patterns
    for (int sz = 1; sz <= 4; sz++)
      for (int ct = 1; ct <= 3; ct++)
        for (int gm = 0; gm < 3; gm++) begin
          logic [AW-1:0] d0;
          d0 = 16'h8000 + AW'(sz * 256 + ct * 16 + gm);
          configure(16'h1000 + AW'(sz * 256 + ct * 16 + gm), d0, sz, ct, gm);
          for (int b = 1; b <= ct; b++) begin
            pulse();
            wait_end(b);
            repeat (2) tick();
          end
          repeat (3) tick();
          @(negedge clk);
          check(!chan_en, "R9 enable cleared", chan_en, 0);
          check(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
          check(int'(exp_dst - d0) == sz * ct, "R3 units moved", int'(exp_dst - d0), sz * ct);
          base = blk_started;
          pulse();
          repeat (8) tick();
          @(negedge clk);
          check(blk_started == base && !bus_req, "R9 pin ignored when disabled", blk_started - base, 0);
        end

    // directed pin waveforms
    configure(16'h2000, 16'h3000, 2, 5, 0);
    base = blk_started;
    tick(); req_n = 1'b0;
    repeat (40) tick();
    check(blk_started - base == 1, "R6 held low gives one block", blk_started - base, 1);
    req_n = 1'b1; tick(); req_n = 1'b0;
    repeat (30) tick();
    check(blk_started - base == 2, "R8 reopen on late high", blk_started - base, 2);
    req_n = 1'b1; tick();

    pulse();
    tick();
    req_n = 1'b0; tick(); req_n = 1'b1;
    repeat (30) tick();
    check(blk_started - base == 3, "R7 low inside block ignored", blk_started - base, 3);

    pulse();
    repeat (4) tick();
    req_n = 1'b0;
    wait_end(5);
    req_n = 1'b1;
    check(blk_started - base == 5, "R7 low after high retriggers", blk_started - base, 5);
    check(last_gap == GAP + 1, "R7 immediate reopen gap", last_gap, GAP + 1);
    repeat (4) tick();
    check(done_cnt == 1 && !chan_en, "R9 five block run", done_cnt, 1);
    base = blk_started;
    for (int k = 0; k < 10; k++) begin tick(); req_n = ~req_n; end
    req_n = 1'b1;
    repeat (5) tick();
    @(negedge clk);
    check(blk_started == base && !bus_req, "R9 toggling ignored", blk_started - base, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule